// File: doc/BRIEF.md
# Channel Step and Scan Controller

This block selects one of a small set of receiver channels and asks a separate synthesizer programmer to tune to it. A single active-low push button steps through the channels by hand, one channel for each debounced press. Pressing once more from the highest channel switches the block into an automatic scan. The scan walks the channels in a ring, waits for the synthesizer to report lock on each one, and stays on any channel whose squelch is open. A press during the scan returns the block to manual stepping, and the first press after that selects channel 0.

Each tune goes through a request/done handshake with the programmer. Once that completes, an LED indicator is refreshed over a two-wire serial link (data and shift clock), one bit for each channel, with the current channel's LED driven low. All waits are whole multiples of one interval, about 55 ms. The length of that interval is set in clock cycles by a parameter, so a short value can be used when testing.

Top module: `chscan_top`

## Requirements
- R1: A button edge (high-to-low for a press, low-to-high for a release) is acted on once. After an accepted edge the button is ignored for one full interval, so bounce within that interval causes no extra step.
- R2: After reset the block waits POWERUP_TICKS intervals. It then requests a load of channel 0 with `scan_active` low.
- R3: In manual mode, a press on channel k (k below NUM_CHAN-1) requests a load of channel k+1. The request rises one interval after the press reaches the synchronizer.
- R4: A press on the highest channel in manual mode sets `scan_active` and requests a load of channel 0 in the same cycle.
- R5: In scan mode, after a load the block waits for the button to be released and then for `pll_lock` to be high. Until both have happened, no further load is requested.
- R6: In scan mode, once lock is seen the block waits one interval and then checks squelch at the end of the next interval. If squelch is closed (`sql_open` low), it advances to the next channel, wrapping from NUM_CHAN-1 to 0.
- R7: If squelch is open at a check, the block dwells for DWELL_TICKS intervals before checking again.
- R8: A low button at the end of any check or dwell interval clears `scan_active` without a load. The block then waits for release, and the next press loads channel 0 in manual mode.
- R9: Each completed load is followed by one LED frame of NUM_CHAN shift-clock rising edges. The bit sent with the j-th rising edge (j counted from 0) is 0 when j equals the loaded channel and 1 otherwise. `led_sdata` rests high and `led_sclk` rests low outside a frame.
- R10: `load_req` stays high, with `load_chan` unchanged, until a cycle in which `load_done` is high.
- R11: During reset, `load_req` and `led_sclk` are low, `led_sdata` is high and `scan_active` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_n | input | 1 | Push button, low while pressed (asynchronous) |
| sql_open | input | 1 | Squelch open, high on channel activity (asynchronous) |
| pll_lock | input | 1 | Synthesizer lock indication (asynchronous) |
| load_done | input | 1 | Programmer has finished the requested load |
| load_req | output | 1 | Request to program `load_chan` |
| load_chan | output | $clog2(NUM_CHAN) | Current channel |
| scan_active | output | 1 | High while in scan mode |
| led_sdata | output | 1 | LED shift-register serial data |
| led_sclk | output | 1 | LED shift-register clock, data taken on rising edge |

## Verification
A press on `btn_n` passes two synchronizer stages and one full interval. The load request then rises, and the bench's programmer model answers three clock edges later, so a manual load is logged between TICK+2 and TICK+12 cycles after the press. In scan mode, load-to-load gaps are checked against windows built from whole intervals: three intervals plus the 17-cycle LED frame between unattended steps, and forty-four intervals around a dwell. Each window's upper slack is only a few tens of cycles, far less than one interval. LED bits are sampled one time unit after each shift-clock rise, and idle levels are sampled two clocks after the frame's last falling edge.

// File: rtl/chscan_pkg.sv
package chscan_pkg;

  typedef enum logic [3:0] {
    ST_PWR,          // power-up settling
    ST_LOAD,         // waiting on programmer
    ST_LED,          // LED frame in flight
    ST_REL_WAIT,     // waiting for button high
    ST_REL_SETTLE,   // release settling interval
    ST_IDLE,         // manual: waiting for press
    ST_PRESS_SETTLE, // press settling interval
    ST_LOCK_WAIT,    // scan: waiting for lock
    ST_LOCK_SETTLE,  // scan: post-lock interval
    ST_CHECK,        // scan: squelch check interval
    ST_DWELL         // scan: dwelling on active channel
  } scan_state_e;

endpackage

// File: rtl/chscan_sync.sv
module chscan_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/chscan_tick.sv
module chscan_tick #(
  parameter int TICK_CYCLES = 2750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int TW = $clog2(TICK_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == TW'(TICK_CYCLES - 1));

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/chscan_led.sv
module chscan_led #(
  parameter int NUM_LED = 8,
  localparam int IW     = $clog2(NUM_LED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] sel,
  output logic          sdata,
  output logic          sclk,
  output logic          done
);

  localparam logic [IW-1:0] LAST = IW'(NUM_LED - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          sclk_q, sclk_d;
  logic          sdata_q, sdata_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    sclk_d  = sclk_q;
    sdata_d = sdata_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        sclk_d  = 1'b0;
        sdata_d = (sel != '0);
      end
    end else if (!sclk_q) begin
      sclk_d = 1'b1;
    end else begin
      sclk_d = 1'b0;
      if (idx_q == LAST) begin
        busy_d  = 1'b0;
        sdata_d = 1'b1;
        done_d  = 1'b1;
      end else begin
        idx_d   = idx_q + IW'(1);
        sdata_d = (sel != (idx_q + IW'(1)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      sclk_q  <= sclk_d;
      sdata_q <= sdata_d;
      done_q  <= done_d;
    end
  end

  assign sdata = sdata_q;
  assign sclk  = sclk_q;
  assign done  = done_q;

endmodule

// File: rtl/chscan_top.sv
module chscan_top #(
  parameter int NUM_CHAN      = 8,
  parameter int TICK_CYCLES   = 2750000,
  parameter int POWERUP_TICKS = 2,
  parameter int DWELL_TICKS   = 40,
  localparam int CW           = $clog2(NUM_CHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_n,
  input  logic          sql_open,
  input  logic          pll_lock,
  input  logic          load_done,
  output logic          load_req,
  output logic [CW-1:0] load_chan,
  output logic          scan_active,
  output logic          led_sdata,
  output logic          led_sclk
);

  import chscan_pkg::*;

  localparam int            CNT_MAX = (DWELL_TICKS > POWERUP_TICKS) ? DWELL_TICKS : POWERUP_TICKS;
  localparam int            NW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CHAN - 1);

  logic [2:0] sync_q;
  logic       btn_s, sql_s, lock_s;
  logic       tick, tmr_clr;
  logic       led_start, led_done;

  scan_state_e   state_q, state_d;
  logic [CW-1:0] chan_q, chan_d;
  logic          scan_q, scan_d;
  logic          restart_q, restart_d;
  logic [NW-1:0] cnt_q, cnt_d;

  chscan_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pll_lock, sql_open, btn_n}), .q(sync_q)
  );
  assign btn_s  = sync_q[0];
  assign sql_s  = sync_q[1];
  assign lock_s = sync_q[2];

  chscan_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
  );

  chscan_led #(.NUM_LED(NUM_CHAN)) u_led (
    .clk(clk), .rst_n(rst_n), .start(led_start), .sel(chan_q),
    .sdata(led_sdata), .sclk(led_sclk), .done(led_done)
  );

  function automatic logic [CW-1:0] next_chan(input logic [CW-1:0] c);
    return (c == LAST_CH) ? '0 : c + CW'(1);
  endfunction

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    scan_d    = scan_q;
    restart_d = restart_q;
    cnt_d     = cnt_q;
    unique case (state_q)
      ST_PWR: if (tick) begin
        if (cnt_q == NW'(POWERUP_TICKS - 1)) begin
          chan_d  = '0;
          state_d = ST_LOAD;
        end else begin
          cnt_d = cnt_q + NW'(1);
        end
      end
      ST_LOAD:       if (load_done) state_d = ST_LED;
      ST_LED:        if (led_done)  state_d = ST_REL_WAIT;
      ST_REL_WAIT:   if (btn_s)     state_d = ST_REL_SETTLE;
      ST_REL_SETTLE: if (tick)      state_d = scan_q ? ST_LOCK_WAIT : ST_IDLE;
      ST_IDLE:       if (!btn_s)    state_d = ST_PRESS_SETTLE;
      ST_PRESS_SETTLE: if (tick) begin
        state_d = ST_LOAD;
        if (restart_q) begin
          restart_d = 1'b0;
          chan_d    = '0;
        end else if (chan_q == LAST_CH) begin
          scan_d = 1'b1;
          chan_d = '0;
        end else begin
          chan_d = chan_q + CW'(1);
        end
      end
      ST_LOCK_WAIT:   if (lock_s) state_d = ST_LOCK_SETTLE;
      ST_LOCK_SETTLE: if (tick)   state_d = ST_CHECK;
      ST_CHECK: if (tick) begin
        if (!btn_s) begin
          scan_d    = 1'b0;
          restart_d = 1'b1;
          state_d   = ST_REL_WAIT;
        end else if (!sql_s) begin
          chan_d  = next_chan(chan_q);
          state_d = ST_LOAD;
        end else begin
          cnt_d   = '0;
          state_d = ST_DWELL;
        end
      end
      ST_DWELL: if (tick) begin
        if (!btn_s) begin
          scan_d    = 1'b0;
          restart_d = 1'b1;
          state_d   = ST_REL_WAIT;
        end else if (cnt_q == NW'(DWELL_TICKS - 1)) begin
          state_d = ST_CHECK;
        end else begin
          cnt_d = cnt_q + NW'(1);
        end
      end
      default: state_d = ST_PWR;
    endcase
  end

  assign tmr_clr   = (state_d != state_q);
  assign led_start = (state_q == ST_LOAD) && load_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PWR;
      chan_q    <= '0;
      scan_q    <= 1'b0;
      restart_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_d;
      chan_q    <= chan_d;
      scan_q    <= scan_d;
      restart_q <= restart_d;
      cnt_q     <= cnt_d;
    end
  end

  assign load_req    = (state_q == ST_LOAD);
  assign load_chan   = chan_q;
  assign scan_active = scan_q;

endmodule

// File: rtl/chscan_chk.sv
module chscan_chk #(
  parameter int NUM_CHAN = 8,
  localparam int CW      = $clog2(NUM_CHAN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_done,
  input logic          load_req,
  input logic [CW-1:0] load_chan,
  input logic          scan_active,
  input logic          led_sdata,
  input logic          led_sclk
);

  // R10: request held until done
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !load_done |=> load_req);

  // R10: channel stable while request pending
  p_req_chan_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !load_done |=> $stable(load_chan));

  // R4: scan entry loads channel 0 at once
  p_scan_entry_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active) |-> load_req && (load_chan == '0));

  // R8: cancelling scan requests no load
  p_cancel_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_active) |-> !load_req);

  // R9: LED lines idle while a load is pending
  p_led_idle_in_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> !led_sclk && led_sdata);

  // R3: manual loads step by one or restart at 0
  p_manual_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_req) && !scan_active |->
      (load_chan == $past(load_chan) + CW'(1)) || (load_chan == '0));

endmodule

bind chscan_top chscan_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_done(load_done), .load_req(load_req),
  .load_chan(load_chan), .scan_active(scan_active),
  .led_sdata(led_sdata), .led_sclk(led_sclk)
);

// File: tb/chscan_top_tb_top.sv
module chscan_top_tb_top;

  localparam int T   = 40;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, btn_n, sql_open, pll_lock, load_done;
  logic       load_req, scan_active, led_sdata, led_sclk;
  logic [2:0] load_chan;

  chscan_top #(.NUM_CHAN(NCH), .TICK_CYCLES(T), .POWERUP_TICKS(2), .DWELL_TICKS(40)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .sql_open(sql_open), .pll_lock(pll_lock),
    .load_done(load_done), .load_req(load_req), .load_chan(load_chan),
    .scan_active(scan_active), .led_sdata(led_sdata), .led_sclk(led_sclk)
  );

  int checks = 0, fails = 0, cyc = 0, nload = 0, rst_cyc = 0;
  int ld_chan [256];
  int ld_cyc  [256];
  bit ld_scan [256];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // programmer model: answer each request after three edges
  initial begin
    load_done = 1'b0;
    forever begin
      @(negedge clk);
      load_done = 1'b0;
      if (load_req) begin
        repeat (2) @(negedge clk);
        ld_chan[nload] = int'(load_chan);
        ld_cyc[nload]  = cyc;
        ld_scan[nload] = scan_active;
        nload++;
        load_done = 1'b1;
      end
    end
  end

  // LED frame monitor (R9)
  initial begin
    forever begin
      logic [NCH-1:0] got, exp;
      for (int i = 0; i < NCH; i++) begin
        @(posedge led_sclk);
        #1 got[i] = led_sdata;
      end
      for (int i = 0; i < NCH; i++) exp[i] = (i != ld_chan[nload-1]);
      check(got == exp, "R9", "led frame", int'(got), int'(exp));
      @(negedge led_sclk);
      repeat (2) @(negedge clk);
      check(led_sdata == 1'b1 && led_sclk == 1'b0, "R9", "led idle levels",
            int'({led_sdata, led_sclk}), 2);
    end
  end

  task automatic wait_load(input int target, input int limit);
    for (int i = 0; i < limit && nload < target; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic press(input int hold);
    @(negedge clk) btn_n = 1'b0;
    repeat (hold) @(negedge clk);
    btn_n = 1'b1;
    repeat (2*T) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; btn_n = 1'b1; sql_open = 1'b0; pll_lock = 1'b0;
    repeat (5) @(negedge clk);
    check(load_req == 0 && led_sclk == 0 && led_sdata == 1 && scan_active == 0,
          "R11", "reset outputs", int'({load_req, led_sclk, led_sdata, scan_active}), 2);
    rst_n = 1'b1;
    rst_cyc = cyc;
  endtask

  task automatic t_powerup;
    wait_load(1, 10*T);
    check(nload == 1, "R2", "power-up load count", nload, 1);
    check(ld_chan[0] == 0 && !ld_scan[0], "R2", "power-up channel", ld_chan[0], 0);
    check(ld_cyc[0] - rst_cyc >= 2*T, "R2", "power-up delay", ld_cyc[0] - rst_cyc, 2*T);
    repeat (2*T) @(negedge clk);
  endtask

  task automatic t_bounce;
    int n0 = nload;
    @(negedge clk) btn_n = 1'b0;
    repeat (3) @(negedge clk); btn_n = 1'b1;
    repeat (3) @(negedge clk); btn_n = 1'b0;
    repeat (3) @(negedge clk); btn_n = 1'b1;
    repeat (2) @(negedge clk); btn_n = 1'b0;
    repeat (2*T) @(negedge clk); btn_n = 1'b1;
    repeat (2) @(negedge clk); btn_n = 1'b0;
    repeat (2) @(negedge clk); btn_n = 1'b1;
    repeat (3*T) @(negedge clk);
    check(nload == n0 + 1, "R1", "bounced press load count", nload - n0, 1);
    check(ld_chan[nload-1] == 1, "R1", "bounced press channel", ld_chan[nload-1], 1);
  endtask

  task automatic t_manual;
    for (int k = 2; k < NCH; k++) begin
      int p = cyc;
      press(2*T);
      check(ld_chan[nload-1] == k && !ld_scan[nload-1], "R3", "manual step channel",
            ld_chan[nload-1], k);
      check(ld_cyc[nload-1] - p >= T + 2 && ld_cyc[nload-1] - p <= T + 12, "R3",
            "press to load cycles", ld_cyc[nload-1] - p, T + 6);
    end
  endtask

  task automatic t_scan_enter;
    int n0 = nload;
    int l;
    pll_lock = 1'b0; sql_open = 1'b0;
    @(negedge clk) btn_n = 1'b0;
    repeat (6*T) @(negedge clk);
    check(nload == n0 + 1, "R4", "overflow load count", nload - n0, 1);
    check(ld_chan[nload-1] == 0 && ld_scan[nload-1], "R4", "scan entry channel",
          ld_chan[nload-1], 0);
    check(scan_active == 1'b1, "R4", "scan_active after overflow", scan_active, 1);
    btn_n = 1'b1;
    repeat (4*T) @(negedge clk);
    check(nload == n0 + 1, "R5", "no step while unlocked", nload - n0, 1);
    pll_lock = 1'b1;
    l = cyc;
    wait_load(n0 + 2, 6*T);
    check(ld_chan[nload-1] == 1, "R5", "channel after lock", ld_chan[nload-1], 1);
    check(ld_cyc[nload-1] - l >= 2*T && ld_cyc[nload-1] - l <= 2*T + 12, "R5",
          "lock to load cycles", ld_cyc[nload-1] - l, 2*T + 6);
  endtask

  task automatic t_wrap;
    for (int k = 2; k <= 9; k++) begin
      int n0 = nload;
      wait_load(n0 + 1, 6*T);
      check(ld_chan[nload-1] == k % NCH, "R6", "scan advance channel", ld_chan[nload-1], k % NCH);
      check(ld_cyc[nload-1] - ld_cyc[nload-2] >= 3*T &&
            ld_cyc[nload-1] - ld_cyc[nload-2] <= 3*T + 32, "R6", "scan step gap",
            ld_cyc[nload-1] - ld_cyc[nload-2], 3*T + 24);
    end
  endtask

  task automatic t_dwell;
    int n0 = nload;
    sql_open = 1'b1;
    repeat (20*T) @(negedge clk);
    sql_open = 1'b0;
    wait_load(n0 + 1, 40*T);
    check(nload == n0 + 1 && ld_chan[nload-1] == 2, "R7", "channel after dwell",
          ld_chan[nload-1], 2);
    check(ld_cyc[nload-1] - ld_cyc[nload-2] >= 44*T &&
          ld_cyc[nload-1] - ld_cyc[nload-2] <= 44*T + 32, "R7", "dwell gap",
          ld_cyc[nload-1] - ld_cyc[nload-2], 44*T + 24);
  endtask

  task automatic t_cancel;
    int n0 = nload;
    repeat (T*3/2) @(negedge clk);
    btn_n = 1'b0;
    repeat (T*7/2) @(negedge clk);
    check(scan_active == 1'b0, "R8", "scan_active after press", scan_active, 0);
    btn_n = 1'b1;
    repeat (3*T) @(negedge clk);
    check(nload == n0, "R8", "no load on cancel", nload - n0, 0);
    press(2*T);
    check(nload == n0 + 1 && ld_chan[nload-1] == 0 && !ld_scan[nload-1], "R8",
          "first press after cancel", ld_chan[nload-1], 0);
    press(2*T);
    check(ld_chan[nload-1] == 1 && !ld_scan[nload-1], "R3", "manual step after cancel",
          ld_chan[nload-1], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_powerup;
    t_bounce;
    t_manual;
    t_scan_enter;
    t_wrap;
    t_dwell;
    t_cancel;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule